// File: doc/BRIEF.md
# Wake-capable external pin interrupt detector

This block watches up to eight external interrupt pins and turns activity on them into a per-pin interrupt flag and one combined request line. Each pin has its own two-bit sensing mode (low level, rising edge, falling edge or either edge) and its own enable. Edge events are caught on the block clock after a two-stage synchroniser and kept in a sticky flag that software clears by writing a one. A level-sensed flag simply mirrors the pin, so it stays set while the pin is held low.

The request can bring the system out of its low-power states. In the light sleep states the clock keeps running and the block behaves exactly as in normal operation. In the deep sleep state the clock is gone. The power controller raises `stop_i` while the clock is stopped, and all clocked state holds its value. Edge sensing is therefore off, and only a purely combinational path remains: a low level on an enabled pin in level mode drives the request with no clock at all.

Top module: `wake_irq_detect`

## Requirements
- R1: While reset is asserted and right after it is released with all pins high, every flag and the request are 0.
- R2: Mode code 2'b01 (bits [2i+1:2i] of `mode_i` for pin i) senses rising edges. A low-to-high pin change shows in `flag_o[i]` exactly three clock edges after it is applied. Falling changes do not set the flag.
- R3: Mode code 2'b10 senses falling edges only, with the same three-edge latency.
- R4: Mode code 2'b11 senses both rising and falling edges.
- R5: An edge flag stays set after the pin returns to its old level. It is cleared on the clock edge where bit i of `clr_i` is 1. Clear bits of other pins do not affect it.
- R6: When an edge event and a clear for the same pin fall on the same clock edge, the flag ends up set.
- R7: Mode code 2'b00 senses a low level. Outside stop, `flag_o[i]` equals the inverted pin two clock edges after a change, and a clear has no effect while the pin is low.
- R8: `req_o` is 1 exactly when some pin has both its flag and its enable set. A flag on a disabled pin does not raise the request.
- R9: While `stop_i` is 1, edge flags hold their value. A pin pulse that begins and ends inside stop sets no flag, and a clear written during stop is ignored.
- R10: While `stop_i` is 1, an enabled pin in mode 2'b00 that is driven low raises `flag_o[i]` and `req_o` with no clock edge.
- R11: While `stop_i` is 1, a low pin raises no request if it is disabled or if it is set to an edge mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, absent (held) during stop |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Raw external interrupt pins |
| mode_i | input | 2*NUM_PINS | Per-pin sensing mode, two bits per pin |
| en_i | input | NUM_PINS | Per-pin request enable |
| stop_i | input | 1 | High while the system is in deep stop |
| clr_i | input | NUM_PINS | Write-one-to-clear strobe for edge flags |
| flag_o | output | NUM_PINS | Per-pin interrupt flag |
| req_o | output | 1 | Combined wake / interrupt request |

## Verification
An edge event and a software clear of the same pin's flag can land on one clock edge. The bench sets this up by raising a rising-edge pin and then asserting the clear exactly on the third edge, which is the edge where the synchronised rise is first registered. The flag is then judged set, and the test starts from a cleared flag so that a clear-wins design would show 0. A second collision happens in stop: a clear arrives while the flag is frozen, and it must leave the flag set after stop ends.

// File: rtl/wid_pkg.sv
package wid_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_RISE = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;

    typedef struct packed {
        logic prev;        // synchronised pin value seen on the previous edge
        logic edge_flag;   // sticky edge event flag
    } pin_state_t;

endpackage

// File: rtl/wid_sync.sv
module wid_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (!hold) begin
            chain_d = {chain_q[STAGES-2:0], d};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/wid_pin.sv
module wid_pin
    import wid_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_i,
    input  logic       pin_i,
    input  logic [1:0] mode_i,
    input  logic       clr_i,
    output logic       flag_o
);
    logic       pin_s;
    logic       rise, fall, hit;
    pin_state_t st_d, st_q;

    wid_sync #(
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .hold (stop_i),
        .d    (pin_i),
        .q    (pin_s)
    );

    always_comb begin
        rise = pin_s & ~st_q.prev;
        fall = ~pin_s & st_q.prev;
        case (mode_i)
            SENSE_RISE: hit = rise;
            SENSE_FALL: hit = fall;
            SENSE_BOTH: hit = rise | fall;
            default:    hit = 1'b0;
        endcase

        st_d = st_q;
        if (!stop_i) begin
            st_d.prev = pin_s;
            if (mode_i == SENSE_LOW) begin
                st_d.edge_flag = 1'b0;
            end else if (hit) begin
                st_d.edge_flag = 1'b1;       // event beats clear
            end else if (clr_i) begin
                st_d.edge_flag = 1'b0;
            end
        end

        if (mode_i == SENSE_LOW) begin
            flag_o = stop_i ? ~pin_i : ~pin_s;
        end else begin
            flag_o = st_q.edge_flag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{prev: 1'b1, edge_flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wake_irq_detect.sv
module wake_irq_detect #(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_i,
    input  logic [2*NUM_PINS-1:0] mode_i,
    input  logic [NUM_PINS-1:0]   en_i,
    input  logic                  stop_i,
    input  logic [NUM_PINS-1:0]   clr_i,
    output logic [NUM_PINS-1:0]   flag_o,
    output logic                  req_o
);
    logic [NUM_PINS-1:0] flag_w;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        wid_pin #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_pin (
            .clk   (clk),
            .rst_n (rst_n),
            .stop_i(stop_i),
            .pin_i (pin_i[g]),
            .mode_i(mode_i[2*g +: 2]),
            .clr_i (clr_i[g]),
            .flag_o(flag_w[g])
        );
    end

    always_comb begin
        flag_o = flag_w;
        req_o  = |(flag_w & en_i);
    end
endmodule

// File: rtl/wid_chk.sv
module wid_chk #(
    parameter int NUM_PINS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_PINS-1:0]   pin_i,
    input logic [2*NUM_PINS-1:0] mode_i,
    input logic [NUM_PINS-1:0]   en_i,
    input logic                  stop_i,
    input logic [NUM_PINS-1:0]   clr_i,
    input logic [NUM_PINS-1:0]   flag_o,
    input logic                  req_o
);
    // R8: request reflects enabled flags
    a_r8_req_tracks_flags: assert property (@(posedge clk) disable iff (!rst_n)
        req_o == |(flag_o & en_i));

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
        // R5: edge flag survives unless cleared
        a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (!stop_i && mode_i[2*g +: 2] != 2'b00 && flag_o[g] && !clr_i[g])
            |=> (mode_i[2*g +: 2] == 2'b00 || flag_o[g]));

        // R9: stop freezes edge flags
        a_r9_stop_freeze: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_i && mode_i[2*g +: 2] != 2'b00)
            |=> (mode_i[2*g +: 2] == 2'b00 || $stable(flag_o[g])));

        // R10: low level wakes in stop
        a_r10_stop_level_wake: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_i && en_i[g] && mode_i[2*g +: 2] == 2'b00 && !pin_i[g]) |-> req_o);

        // R11: high pin in level mode shows no flag in stop
        a_r11_stop_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_i && mode_i[2*g +: 2] == 2'b00 && pin_i[g]) |-> !flag_o[g]);
    end
endmodule

bind wake_irq_detect wid_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pin_i),
    .mode_i(mode_i),
    .en_i  (en_i),
    .stop_i(stop_i),
    .clr_i (clr_i),
    .flag_o(flag_o),
    .req_o (req_o)
);

// File: tb/wake_irq_detect_tb.sv
module wake_irq_detect_tb;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [N-1:0]   pin;
    logic [2*N-1:0] mode;
    logic [N-1:0]   en;
    logic           stop;
    logic [N-1:0]   clr;
    logic [N-1:0]   flag;
    logic           req;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    wake_irq_detect #(.NUM_PINS(N), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .mode_i(mode), .en_i(en),
        .stop_i(stop), .clr_i(clr), .flag_o(flag), .req_o(req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input int idx, input logic [1:0] m);
        mode[2*idx +: 2] = m;
    endtask

    task automatic clear_all();
        clr = '1;
        wait_n(1);
        clr = '0;
    endtask

    task automatic t_reset();
        wait_n(3);
        check("R1 flags in reset", flag, 0);
        check("R1 req in reset", req, 0);
        rst_n = 1'b1;
        wait_n(2);
        check("R1 flags after reset", flag, 0);
        check("R1 req after reset", req, 0);
    endtask

    task automatic t_rise();
        pin[0] = 1'b0; wait_n(3);
        check("R2 falling ignored", flag[0], 0);
        pin[0] = 1'b1; wait_n(2);
        check("R2 not before third edge", flag[0], 0);
        wait_n(1);
        check("R2 rise sets flag", flag[0], 1);
        clear_all();
        check("R5 clear edge flag", flag[0], 0);
    endtask

    task automatic t_fall();
        set_mode(1, 2'b10); wait_n(1);
        pin[1] = 1'b0; wait_n(3);
        check("R3 fall sets flag", flag[1], 1);
        clear_all();
        pin[1] = 1'b1; wait_n(3);
        check("R3 rise ignored", flag[1], 0);
    endtask

    task automatic t_both();
        set_mode(2, 2'b11); wait_n(1);
        pin[2] = 1'b0; wait_n(3);
        check("R4 fall sets flag", flag[2], 1);
        clear_all();
        pin[2] = 1'b1; wait_n(3);
        check("R4 rise sets flag", flag[2], 1);
        clear_all();
    endtask

    task automatic t_sticky();
        pin[3] = 1'b0; wait_n(3);
        pin[3] = 1'b1; wait_n(3);
        check("R5 flag set", flag[3], 1);
        pin[3] = 1'b0; wait_n(3);
        check("R5 flag sticky after pin returns", flag[3], 1);
        clr = 8'h01; wait_n(1); clr = '0;
        check("R5 other clear bit no effect", flag[3], 1);
        clr = 8'h08; wait_n(1); clr = '0;
        check("R5 own clear bit clears", flag[3], 0);
    endtask

    task automatic t_collide();
        pin[4] = 1'b0; wait_n(3);
        check("R6 start cleared", flag[4], 0);
        pin[4] = 1'b1; wait_n(2);
        clr[4] = 1'b1; wait_n(1); clr = '0;
        check("R6 event wins over clear", flag[4], 1);
        clear_all();
        check("R6 later clear works", flag[4], 0);
    endtask

    task automatic t_level();
        set_mode(5, 2'b00); wait_n(1);
        check("R7 high pin no flag", flag[5], 0);
        pin[5] = 1'b0; wait_n(1);
        check("R7 latency one edge", flag[5], 0);
        wait_n(1);
        check("R7 low level flag", flag[5], 1);
        clr[5] = 1'b1; wait_n(1); clr = '0;
        check("R7 clear ignored while low", flag[5], 1);
        pin[5] = 1'b1; wait_n(2);
        check("R7 flag follows pin high", flag[5], 0);
    endtask

    task automatic t_req();
        en = '0;
        pin[6] = 1'b0; wait_n(3);
        pin[6] = 1'b1; wait_n(3);
        check("R8 disabled flag set", flag[6], 1);
        check("R8 disabled no req", req, 0);
        en[6] = 1'b1; #1;
        check("R8 enable raises req", req, 1);
        wait_n(1);
        clear_all();
        check("R8 req drops on clear", req, 0);
        en = '0;
    endtask

    task automatic t_stop_edge();
        pin[3] = 1'b1; wait_n(3);
        check("R9 pre-stop flag", flag[3], 1);
        set_mode(7, 2'b11); en = 8'h80; wait_n(1);
        stop = 1'b1; wait_n(1);
        pin[7] = 1'b0; wait_n(3);
        pin[7] = 1'b1; wait_n(2);
        clr = 8'h08; wait_n(1); clr = '0;
        check("R9 pulse in stop no flag", flag[7], 0);
        check("R9 clear in stop ignored", flag[3], 1);
        check("R9 no req in stop", req, 0);
        stop = 1'b0; wait_n(4);
        check("R9 no flag after stop", flag[7], 0);
        check("R9 held flag after stop", flag[3], 1);
        clear_all();
        check("R9 clear after stop", flag[3], 0);
        en = '0;
    endtask

    task automatic t_stop_level();
        en = 8'h20; wait_n(1);
        stop = 1'b1; wait_n(1);
        pin[5] = 1'b0; #1;
        check("R10 level req without clock", req, 1);
        check("R10 level flag without clock", flag[5], 1);
        en = '0; #1;
        check("R11 disabled pin no req", req, 0);
        en = 8'h20; pin[5] = 1'b1; #1;
        check("R11 high pin no req", req, 0);
        en = 8'h40; pin[6] = 1'b0; #1;
        check("R11 edge pin no req in stop", req, 0);
        pin[6] = 1'b1; wait_n(1);
        stop = 1'b0; en = '0; wait_n(4);
        check("R11 no flags after stop", flag, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        pin   = '1;
        mode  = 16'h5555;
        en    = '0;
        stop  = 1'b0;
        clr   = '0;
        t_reset();
        t_rise();
        t_fall();
        t_both();
        t_sticky();
        t_collide();
        t_level();
        t_req();
        t_stop_edge();
        t_stop_level();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

    initial begin
        #200us;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
            $finish;
        end
    end
endmodule